// File: doc/BRIEF.md
# Priority-Level Interrupt Control Unit

This unit sits beside a small processor core and decides, at each instruction boundary, whether an incoming interrupt request may break into the running routine. Each request line carries a 3-bit level where a smaller number means more urgent. A request is accepted only if it is strictly more urgent than the level of the routine currently running. Requests that do not qualify stay pending until that changes. A separate top-level request has its own pending flag and its own masking rules, and it wins over every ordinary request.

An 8-bit control register is visible on a simple register bus. It holds the following fields:
- a global timer gate, which is ANDed with per-timer count enables;
- the top-level pending flag;
- the top-level acceptance mode;
- the interrupt enable;
- the arbitration mode;
- the 3-bit running level.

The core drives one-cycle strobes for return, enable and disable. The unit answers with a one-cycle take pulse, which carries either the winning request index or a top-level flag. In nested mode the running level rises to the accepted level. The level it replaced is recorded in a bit-per-level nesting record, and it is brought back on return.

Top module: `prio_icu`

## Requirements
- R1: After reset, `regRdata` reads 0x87 and `intTake` is low. In the register, bit 7 is the timer gate, bit 6 is top-level pending, bit 5 is top-level mode, bit 4 is interrupt enable, bit 3 is arbitration mode (1 = nested) and bits 2:0 are the running level.
- R2: `timerRun[i]` is high exactly when `timerCe[i]` is high and register bit 7 is 1.
- R3: A `topReq` pulse sets bit 6. A register write with bit 6 = 1 also sets it. Taking the top-level request clears bit 6 and produces `intTake` together with `intTop` = 1.
- R4: Any take clears bit 4. `retStb` and `eiStb` set bit 4. `diStb` clears it. A take or `diStb` overrides a set in the same cycle.
- R5: With bit 4 = 0, no ordinary request is taken. The top-level request is blocked while `topMask` = 1. With bit 5 = 0 it is otherwise taken regardless of bit 4. With bit 5 = 1 it also needs bit 4 = 1.
- R6: A register write updates bit 4 only when no `reqPend` bit is set and bit 6 is 0. The other fields are always written.
- R7: An ordinary request is taken only if its level is numerically lower than bits 2:0.
- R8: Among eligible requests, the lowest level wins and ties go to the lowest index. The top-level request beats all of them. `intTake` is a one-cycle pulse in the cycle after the decision, with `intIdx` = winner index (0 for a top-level take).
- R9: In nested mode, an ordinary take loads bits 2:0 with the winner's level. If the old level was not 7, the old level is marked in the nesting record.
- R10: In nested mode, `retStb` loads bits 2:0 with the lowest-numbered marked level and clears that mark. If no mark is set, it loads 7.
- R11: In concurrent mode (bit 3 = 0), takes and returns leave bits 2:0 unchanged.
- R12: No take of any kind happens while `instBound` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instBound | input | 1 | Core is at an instruction boundary and may be interrupted |
| reqPend | input | NUM_REQ | Level-held request lines |
| reqLvl | input | 3*NUM_REQ | Level of each request, 3 bits per line, line 0 in the low bits |
| topReq | input | 1 | Top-level request pulse |
| topMask | input | 1 | Top-level mask (1 blocks the top-level take) |
| retStb | input | 1 | Return-from-interrupt strobe |
| eiStb | input | 1 | Enable-interrupts strobe |
| diStb | input | 1 | Disable-interrupts strobe |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register read data |
| timerCe | input | NUM_TMR | Per-timer count enables |
| timerRun | output | NUM_TMR | Gated timer run enables |
| intTake | output | 1 | One-cycle take pulse |
| intTop | output | 1 | The take is the top-level one |
| intIdx | output | log2(NUM_REQ) | Index of the taken request |

## Verification
The embedded assertions watch the following on every cycle:
- no ordinary take without the enable, or at a level that is not strictly more urgent;
- the enable is cleared after any take;
- the replaced level is marked in nested mode;
- an empty nesting record returns the level to 7;
- the reset value and the timer gate.

Several behaviours can only be shown by directed scenarios run against the bench's behavioural model:
- winner selection among tied levels;
- the top-level request winning over a simultaneous ordinary one;
- the full nest-and-unwind sequence;
- a register write to the enable being refused while something is pending;
- the two top-level acceptance modes.

// File: rtl/prio_icu_pkg.sv
package prio_icu_pkg;
  localparam int LVL_W = 3;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam logic [LVL_W-1:0] LVL_IDLE = '1;
  localparam logic [7:0] CTRL_RESET = 8'h87;

  // bit positions of the control register
  localparam int B_GATE = 7;
  localparam int B_TLPEND = 6;
  localparam int B_TLMODE = 5;
  localparam int B_IEN = 4;
  localparam int B_NEST = 3;

  typedef struct packed {
    logic takeReq;
    logic takeTop;
    logic ienSet;
    logic ienClr;
    logic restore;
  } icuStb_t;
endpackage

// File: rtl/prio_icu_arb.sv
module prio_icu_arb
  import prio_icu_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0]       reqPend,
  input  logic [NUM_REQ*LVL_W-1:0] reqLvl,
  input  logic [LVL_W-1:0]         cpl,
  output logic                     found,
  output logic [IDX_W-1:0]         winIdx,
  output logic [LVL_W-1:0]         winLvl
);
  logic [LVL_W-1:0] lvl [NUM_REQ];
  logic [NUM_REQ-1:0] elig;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assign lvl[g]  = reqLvl[g*LVL_W +: LVL_W];
    assign elig[g] = reqPend[g] && (lvl[g] < cpl);
  end

  // strict less-than keeps the lowest index on equal levels
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    winLvl = '1;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i] && (!found || lvl[i] < winLvl)) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
        winLvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/prio_icu_ctrl.sv
module prio_icu_ctrl
  import prio_icu_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instBound,
  input  logic             topMask,
  input  logic             retStb,
  input  logic             eiStb,
  input  logic             diStb,
  input  logic             ien,
  input  logic             tlPend,
  input  logic             tlMode,
  input  logic             nestMode,
  input  logic             found,
  input  logic [IDX_W-1:0] winIdx,
  output icuStb_t          stb,
  output logic             intTake,
  output logic             intTop,
  output logic [IDX_W-1:0] intIdx
);
  logic topOk;

  assign topOk = tlPend && !topMask && (!tlMode || ien);

  always_comb begin
    stb.takeTop = instBound && topOk;
    stb.takeReq = instBound && !stb.takeTop && ien && found;
    stb.ienSet  = eiStb || retStb;
    stb.ienClr  = diStb || stb.takeTop || stb.takeReq;
    stb.restore = retStb && nestMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intTake <= 1'b0;
      intTop  <= 1'b0;
      intIdx  <= '0;
    end else begin
      intTake <= stb.takeTop || stb.takeReq;
      intTop  <= stb.takeTop;
      intIdx  <= stb.takeReq ? winIdx : '0;
    end
  end

  // R12: takes only at a boundary
  a_r12_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !instBound |=> !intTake);
endmodule

// File: rtl/prio_icu_dp.sv
module prio_icu_dp
  import prio_icu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regWdata,
  input  logic             topReq,
  input  logic             reqAny,
  input  icuStb_t          stb,
  input  logic [LVL_W-1:0] winLvl,
  output logic             gate,
  output logic             tlPend,
  output logic             tlMode,
  output logic             ien,
  output logic             nestMode,
  output logic [LVL_W-1:0] cpl,
  output logic [7:0]       regRdata
);
  logic [NUM_LVL-1:0] nest, nestN;
  logic gateN, tlPendN, tlModeN, ienN, nestModeN;
  logic [LVL_W-1:0] cplN, restLvl;
  logic pendAny;

  assign pendAny = reqAny || tlPend;

  // most urgent marked level, or idle when none is marked
  always_comb begin
    restLvl = LVL_IDLE;
    for (int l = NUM_LVL - 2; l >= 0; l--) begin
      if (nest[l]) restLvl = LVL_W'(l);
    end
  end

  always_comb begin
    gateN     = gate;
    tlPendN   = tlPend;
    tlModeN   = tlMode;
    ienN      = ien;
    nestModeN = nestMode;
    cplN      = cpl;
    nestN     = nest;
    if (regWe) begin
      gateN     = regWdata[B_GATE];
      tlPendN   = regWdata[B_TLPEND];
      tlModeN   = regWdata[B_TLMODE];
      nestModeN = regWdata[B_NEST];
      cplN      = regWdata[LVL_W-1:0];
      if (!pendAny) ienN = regWdata[B_IEN];
    end
    if (stb.ienSet) ienN = 1'b1;
    if (stb.restore) begin
      cplN = restLvl;
      nestN[restLvl] = 1'b0;
    end
    if (stb.ienClr) ienN = 1'b0;
    if (stb.takeTop) tlPendN = 1'b0;
    if (stb.takeReq && nestMode) begin
      if (cpl != LVL_IDLE) nestN[cpl] = 1'b1;
      cplN = winLvl;
    end
    if (topReq) tlPendN = 1'b1;
    nestN[NUM_LVL-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gate     <= CTRL_RESET[B_GATE];
      tlPend   <= CTRL_RESET[B_TLPEND];
      tlMode   <= CTRL_RESET[B_TLMODE];
      ien      <= CTRL_RESET[B_IEN];
      nestMode <= CTRL_RESET[B_NEST];
      cpl      <= CTRL_RESET[LVL_W-1:0];
      nest     <= '0;
    end else begin
      gate     <= gateN;
      tlPend   <= tlPendN;
      tlMode   <= tlModeN;
      ien      <= ienN;
      nestMode <= nestModeN;
      cpl      <= cplN;
      nest     <= nestN;
    end
  end

  assign regRdata = {gate, tlPend, tlMode, ien, nestMode, cpl};

  // R7: accepted level strictly more urgent than running level
  a_r7_strict_level: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeReq |-> (winLvl < cpl));
  // R5: ordinary takes need the enable
  a_r5_enable_mask: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeReq |-> ien);
  // R4: enable is low after any take
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeReq || stb.takeTop) |=> !ien);
  // R9: replaced level is recorded
  a_r9_mark_saved: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeReq && nestMode && cpl != LVL_IDLE && !stb.restore) |=> nest[$past(cpl)]);
  // R10: empty record unwinds to idle
  a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restore && nest == '0 && !stb.takeReq && !regWe) |=> (cpl == LVL_IDLE));
endmodule

// File: rtl/prio_icu.sv
module prio_icu
  import prio_icu_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int NUM_TMR = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     instBound,
  input  logic [NUM_REQ-1:0]       reqPend,
  input  logic [NUM_REQ*LVL_W-1:0] reqLvl,
  input  logic                     topReq,
  input  logic                     topMask,
  input  logic                     retStb,
  input  logic                     eiStb,
  input  logic                     diStb,
  input  logic                     regWe,
  input  logic [7:0]               regWdata,
  output logic [7:0]               regRdata,
  input  logic [NUM_TMR-1:0]       timerCe,
  output logic [NUM_TMR-1:0]       timerRun,
  output logic                     intTake,
  output logic                     intTop,
  output logic [IDX_W-1:0]         intIdx
);
  icuStb_t stb;
  logic found, gate, tlPend, tlMode, ien, nestMode;
  logic [IDX_W-1:0] winIdx;
  logic [LVL_W-1:0] winLvl, cpl;

  prio_icu_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .reqPend(reqPend), .reqLvl(reqLvl), .cpl(cpl),
    .found(found), .winIdx(winIdx), .winLvl(winLvl)
  );

  prio_icu_ctrl #(.NUM_REQ(NUM_REQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .instBound(instBound), .topMask(topMask),
    .retStb(retStb), .eiStb(eiStb), .diStb(diStb),
    .ien(ien), .tlPend(tlPend), .tlMode(tlMode), .nestMode(nestMode),
    .found(found), .winIdx(winIdx), .stb(stb),
    .intTake(intTake), .intTop(intTop), .intIdx(intIdx)
  );

  prio_icu_dp u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .topReq(topReq), .reqAny(|reqPend), .stb(stb), .winLvl(winLvl),
    .gate(gate), .tlPend(tlPend), .tlMode(tlMode), .ien(ien),
    .nestMode(nestMode), .cpl(cpl), .regRdata(regRdata)
  );

  assign timerRun = timerCe & {NUM_TMR{gate}};

  // R1: register comes out of reset at its defined value
  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (regRdata == CTRL_RESET && !intTake));
  // R2: a cleared gate stops every timer
  a_r2_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[B_GATE] |-> (timerRun == '0));
endmodule

// File: tb/sim_prio_icu.sv
module sim_prio_icu;
  localparam int NR = 8;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instBound = 1'b0;
  logic [NR-1:0] reqPend = '0;
  logic [NR*3-1:0] reqLvl = '0;
  logic topReq = 0, topMask = 0, retStb = 0, eiStb = 0, diStb = 0, regWe = 0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [NT-1:0] timerCe = '0;
  logic [NT-1:0] timerRun;
  logic intTake, intTop;
  logic [2:0] intIdx;

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";

  prio_icu #(.NUM_REQ(NR), .NUM_TMR(NT)) u0 (
    .clk(clk), .rstN(rstN), .instBound(instBound), .reqPend(reqPend), .reqLvl(reqLvl),
    .topReq(topReq), .topMask(topMask), .retStb(retStb), .eiStb(eiStb), .diStb(diStb),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .timerCe(timerCe), .timerRun(timerRun),
    .intTake(intTake), .intTop(intTop), .intIdx(intIdx)
  );

  always #2 clk = ~clk;

  // behavioural reference
  bit mGate, mTlp, mTlm, mIen, mNest, mTake, mTop;
  int mCpl, mIdx;
  int saved[$];

  always @(posedge clk) begin
    bit pendAny, tTop, tReq, oIen, oTlp, oTlm, oNest;
    int best, bestLvl, oCpl, lv, k;
    if (!rstN) begin
      mGate = 1; mTlp = 0; mTlm = 0; mIen = 0; mNest = 0; mCpl = 7;
      mTake = 0; mTop = 0; mIdx = 0; saved.delete();
    end else begin
      oIen = mIen; oTlp = mTlp; oTlm = mTlm; oNest = mNest; oCpl = mCpl;
      pendAny = (reqPend != 0) || oTlp;
      best = -1; bestLvl = 99;
      for (int i = 0; i < NR; i++) begin
        lv = int'(reqLvl[i*3 +: 3]);
        if (reqPend[i] && lv < oCpl && lv < bestLvl) begin best = i; bestLvl = lv; end
      end
      tTop = instBound && oTlp && !topMask && (!oTlm || oIen);
      tReq = instBound && !tTop && oIen && best >= 0;
      if (regWe) begin
        mGate = regWdata[7]; mTlp = regWdata[6]; mTlm = regWdata[5];
        mNest = regWdata[3]; mCpl = int'(regWdata[2:0]);
        if (!pendAny) mIen = regWdata[4];
      end
      if (eiStb || retStb) mIen = 1;
      if (retStb && oNest) begin
        if (saved.size() == 0) mCpl = 7;
        else begin
          k = 0;
          foreach (saved[j]) if (saved[j] < saved[k]) k = j;
          mCpl = saved[k];
          saved.delete(k);
        end
      end
      if (diStb || tTop || tReq) mIen = 0;
      if (tTop) mTlp = 0;
      if (tReq && oNest) begin
        bit have;
        have = 0;
        foreach (saved[j]) if (saved[j] == oCpl) have = 1;
        if (oCpl != 7 && !have) saved.push_back(oCpl);
        mCpl = bestLvl;
      end
      if (topReq) mTlp = 1;
      mTake = tTop || tReq;
      mTop = tTop;
      mIdx = tReq ? best : 0;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk(intTake === mTake, "intTake", int'(intTake), int'(mTake));
      chk(intTop === mTop, "intTop", int'(intTop), int'(mTop));
      chk(int'(intIdx) == mIdx, "intIdx", int'(intIdx), mIdx);
      chk(regRdata === {mGate, mTlp, mTlm, mIen, mNest, 3'(mCpl)}, "regRdata",
          int'(regRdata), int'({mGate, mTlp, mTlm, mIen, mNest, 3'(mCpl)}));
      chk(timerRun === (timerCe & {NT{mGate}}), "timerRun",
          int'(timerRun), int'(timerCe & {NT{mGate}}));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(logic [7:0] v);
    regWe = 1; regWdata = v; step(); regWe = 0; step(2);
  endtask
  task automatic ei(); eiStb = 1; step(); eiStb = 0; step(2); endtask
  task automatic di(); diStb = 1; step(); diStb = 0; step(2); endtask
  task automatic ret(); retStb = 1; step(); retStb = 0; step(2); endtask
  task automatic top(); topReq = 1; step(); topReq = 0; step(3); endtask
  task automatic req(int idx, int lvl); reqPend[idx] = 1; reqLvl[idx*3 +: 3] = 3'(lvl); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3); rstN = 1; step(3);
    phase = "R2 timer gate";
    timerCe = 4'b1011; step(2);
    wr(8'h07); wr(8'h87);
    phase = "R4 enable strobes";
    ei(); di(); ei(); ret(); di();
    phase = "R12 boundary";
    ei(); req(2, 3); step(4);
    instBound = 1; step(3); reqPend = '0; step(2);
    phase = "R8 arbitration";
    ei(); req(1, 5); req(3, 2); req(6, 2); step(3);
    reqPend[3] = 0; ret();
    reqPend[6] = 0; ei(); reqPend = '0; step(2);
    phase = "R6 guarded enable write";
    req(0, 0); wr(8'h97); reqPend = '0; step(2); wr(8'h97);
    phase = "R7 strict level";
    wr(8'h93); req(0, 3); step(3); req(0, 4); step(3); req(0, 2); step(3);
    reqPend = '0; step(2);
    phase = "R9 nested take";
    wr(8'h9F); req(0, 5); step(3); reqPend = '0;
    ei(); req(1, 2); step(3); reqPend = '0;
    ei(); req(2, 0); step(3); reqPend = '0; step(2);
    phase = "R10 nested return";
    ret(); ret(); ret(); ret();
    phase = "R11 concurrent";
    wr(8'h94); req(4, 1); step(3); reqPend = '0; ret(); step(2);
    phase = "R5 masking";
    di(); req(5, 0); step(4); ei(); reqPend = '0; step(2);
    phase = "R3 top-level";
    wr(8'h87); top();
    topMask = 1; top(); step(2); topMask = 0; step(3);
    wr(8'hA7); top(); ei();
    wr(8'hC7); step(3);
    phase = "R8 top beats ordinary";
    wr(8'h87); instBound = 0; top(); ei(); req(0, 0); step(2);
    instBound = 1; step(3); reqPend = '0; step(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule